// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Store Controller with Keyed Write

This block sits behind a small register port and manages a byte-wide non-volatile data store. The store is modelled inside the block as a register array. Software places a location in the address register. To read, it sets the read bit, and the stored byte appears in the data register. To write, it places a byte in the data register, sets the write-enable bit, and writes the key bytes 55h and then AAh to a write-only key register. The write-start bit must be set immediately after that.

An accepted write runs as a timed job with two phases. The first phase erases the target byte to all ones. The second phase programs the new value. While the job runs, the write-start bit reads back as 1. When the job ends, the bit drops and a sticky completion flag rises. The flag also drives an output pin, and software clears it. A start attempt without a fresh key, or with write-enable low, does not start a job and raises a sticky error bit. The array is not reset, so its contents survive a reset of the controller.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset the control register reads 00h, `done_o` is 0 and any key progress is discarded. A key entered before the reset does not allow a start afterwards.
- R2: A register is chosen by `reg_sel`: 0 is the address, 1 is the data and 2 is the control register. Code 3 is the key register, which accepts writes and always reads 00h. The address and data registers read back the last value written to them.
- R3: A start is accepted only if the bus writes just before it were 55h and then AAh to the key register. Any other write in between (a different key value, or a write to another register) breaks the sequence. In that case the start is refused and the error bit is set. A repeated 55h before AAh keeps the sequence alive.
- R4: A start issued while the write-enable bit (control bit 2) is 0 is refused and sets the error bit (control bit 3).
- R5: An accepted start (control bit 1 written as 1) holds control bit 1 at 1 for exactly ERASE_CYC+PROG_CYC cycles. After that, bit 1 reads 0, and the completion flag (control bit 4) and `done_o` read 1. Writing 1 to bit 3 or bit 4 keeps that flag; writing 0 clears it.
- R6: After a completed write, the addressed byte holds the new value whatever it held before. The job erases the byte and then programs it. Other locations are unchanged.
- R7: Writing 1 to control bit 0 sets that bit for exactly one cycle. The data register then holds the byte at the current address.
- R8: While a write job runs, read requests and further start requests are ignored. They set no error, and the running job finishes with the byte it latched at its start.
- R9: A reset leaves the array contents as they were.
- R10: Each start attempt uses up the key, whether the attempt is accepted or refused. A second start without a new key is refused with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register (combinational) |
| done_o | output | 1 | Completion flag, mirrors control bit 4 |

## Verification
Register writes take effect at the edge that captures them. The bench samples half a cycle after that edge, so the write-start and read bits are checked at the first sample after their request. The read result is checked one sample later, when the read bit has dropped again. For a write, the busy bit is checked at the first sample after the start. It is then checked again exactly ERASE_CYC+PROG_CYC-1 samples later, where it must still be 1, and at the following sample, where it must have cleared with the completion flag set. This pins the job length to the cycle. Refused starts are checked at the first sample after the attempt: the error bit must be set and the busy bit must be 0. The stored byte is then read back to show that nothing changed.

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC = 6,
  parameter logic [DW-1:0] KEY_FIRST = 'h55,
  parameter logic [DW-1:0] KEY_SECOND = 'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          done_o
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CTRL = 2'd2, SEL_KEY = 2'd3;
  localparam int B_RD = 0, B_WR = 1, B_WEN = 2, B_ERR = 3, B_DONE = 4;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_ARMED} ul_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} ph_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q, wr_addr_q;
  logic [DW-1:0] data_q, wr_data_q;
  logic          rd_pend, wen_q, err_q, done_q;
  ul_t           ul_q;
  ph_t           ph_q;
  logic [CW-1:0] cnt_q;

  wire busy      = (ph_q != PH_IDLE);
  wire last      = (cnt_q == '0);
  wire ctrl_wr   = reg_we && (reg_sel == SEL_CTRL);
  wire key_wr    = reg_we && (reg_sel == SEL_KEY);
  wire start_req = ctrl_wr && reg_wdata[B_WR] && !busy;
  wire start_ok  = start_req && reg_wdata[B_WEN] && (ul_q == UL_ARMED);
  wire start_bad = start_req && !start_ok;
  wire finish    = (ph_q == PH_PROG) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) ul_q <= UL_IDLE;
    else if (reg_we) begin
      if (key_wr && reg_wdata == KEY_SECOND && ul_q == UL_HALF) ul_q <= UL_ARMED;
      else if (key_wr && reg_wdata == KEY_FIRST) ul_q <= UL_HALF;
      else ul_q <= UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      cnt_q <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_ok) begin
          ph_q <= PH_ERASE;
          cnt_q <= CW'(ERASE_CYC - 1);
          wr_addr_q <= addr_q;
          wr_data_q <= data_q;
        end
        PH_ERASE: if (last) begin
          ph_q <= PH_PROG;
          cnt_q <= CW'(PROG_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PROG: if (last) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ph_q == PH_ERASE && last) mem[wr_addr_q] <= '1;
    else if (finish) mem[wr_addr_q] <= wr_data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wen_q <= 1'b0;
      err_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rd_pend <= ctrl_wr && reg_wdata[B_RD] && !busy;
      if (ctrl_wr) wen_q <= reg_wdata[B_WEN];
      if (start_bad) err_q <= 1'b1;
      else if (ctrl_wr) err_q <= err_q & reg_wdata[B_ERR];
      if (finish) done_q <= 1'b1;
      else if (ctrl_wr) done_q <= done_q & reg_wdata[B_DONE];
      if (reg_we && reg_sel == SEL_ADDR) addr_q <= reg_wdata[AW-1:0];
      if (rd_pend) data_q <= mem[addr_q];
      else if (reg_we && reg_sel == SEL_DATA) data_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata[AW-1:0] = addr_q;
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: begin
        reg_rdata[B_RD] = rd_pend;
        reg_rdata[B_WR] = busy;
        reg_rdata[B_WEN] = wen_q;
        reg_rdata[B_ERR] = err_q;
        reg_rdata[B_DONE] = done_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign done_o = done_q;
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_sel,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic          rd_pend,
  input logic          busy,
  input logic          err_q,
  input logic          done_q,
  input logic          armed
);
  assert_rd_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> !rd_pend);
  assert_start_keyed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_sel == 2'd2 && reg_wdata[1] && reg_wdata[2]));
  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy));
  assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == 2'd2 && reg_wdata[0]) |=> !rd_pend);
  assert_err_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(reg_we && reg_sel == 2'd2 && reg_wdata[1] && !busy));
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .rd_pend(rd_pend), .busy(busy), .err_q(err_q), .done_q(done_q),
  .armed(ul_q == UL_ARMED)
);

// File: tb/nvbyte_ctrl_tb.sv
`timescale 1ns/1ps
module nvbyte_ctrl_tb;
  localparam int E = 4, P = 6;
  localparam logic [1:0] A = 2'd0, D = 2'd1, C = 2'd2, K = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic done_o;
  int n_chk = 0, n_err = 0;

  nvbyte_ctrl #(.AW(8), .DW(8), .ERASE_CYC(E), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_o(done_o));

  always #2 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] s, logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic peek(logic [1:0] s, output logic [7:0] v);
    reg_sel = s; #0.5; v = reg_rdata;
  endtask

  task automatic write_byte(logic [7:0] a, logic [7:0] d);
    logic [7:0] v;
    bus_wr(A, a); bus_wr(D, d); bus_wr(C, 8'h04);
    bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(C, 8'h06);
    peek(C, v); check("R5 busy after start", v, 8'h06);
    repeat (E + P - 1) @(negedge clk);
    peek(C, v); check("R5 busy at last cycle", v, 8'h06);
    @(negedge clk);
    peek(C, v); check("R5 done after job", v, 8'h14);
    check("R5 done_o", {7'd0, done_o}, 8'h01);
  endtask

  task automatic read_byte(logic [7:0] a, output logic [7:0] d);
    logic [7:0] v;
    bus_wr(A, a); bus_wr(C, 8'h05);
    peek(C, v); check("R7 read bit set", v, 8'h05);
    @(negedge clk);
    peek(C, v); check("R7 read bit cleared", v, 8'h04);
    peek(D, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(C, v); check("R1 ctrl after reset", v, 8'h00);
    check("R1 done_o after reset", {7'd0, done_o}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    bus_wr(A, 8'h5A); peek(A, v); check("R2 address readback", v, 8'h5A);
    bus_wr(D, 8'hA5); peek(D, v); check("R2 data readback", v, 8'hA5);
    bus_wr(K, 8'h55); peek(K, v); check("R2 key reads zero", v, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    write_byte(8'h10, 8'h3C);
    bus_wr(C, 8'h1C); peek(C, v); check("R5 write-1 keeps done", v, 8'h14);
    bus_wr(C, 8'h04); peek(C, v); check("R5 write-0 clears done", v, 8'h04);
    read_byte(8'h10, v); check("R7 read value", v, 8'h3C);
  endtask

  task automatic t_overwrite;
    logic [7:0] v;
    write_byte(8'h10, 8'hC3);
    write_byte(8'h11, 8'h77);
    read_byte(8'h10, v); check("R6 overwritten byte", v, 8'hC3);
    read_byte(8'h11, v); check("R6 neighbour byte", v, 8'h77);
  endtask

  task automatic t_bad_key;
    logic [7:0] v;
    bus_wr(A, 8'h10); bus_wr(D, 8'h00); bus_wr(C, 8'h04);
    bus_wr(K, 8'h55); bus_wr(K, 8'h00); bus_wr(K, 8'hAA); bus_wr(C, 8'h06);
    peek(C, v); check("R3 broken key refused", v, 8'h0C);
    bus_wr(C, 8'h04);
    bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(A, 8'h10); bus_wr(C, 8'h06);
    peek(C, v); check("R3 write between key and start refused", v, 8'h0C);
    read_byte(8'h10, v); check("R3 byte untouched", v, 8'hC3);
    bus_wr(D, 8'h81); bus_wr(C, 8'h04);
    bus_wr(K, 8'h55); bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(C, 8'h06);
    peek(C, v); check("R3 repeated first key accepted", v, 8'h06);
    repeat (E + P) @(negedge clk);
    read_byte(8'h10, v); check("R3 keyed write landed", v, 8'h81);
  endtask

  task automatic t_wen_low;
    logic [7:0] v;
    bus_wr(C, 8'h00); bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(C, 8'h02);
    peek(C, v); check("R4 start with enable low", v, 8'h08);
  endtask

  task automatic t_key_used;
    logic [7:0] v;
    write_byte(8'h20, 8'h42);
    bus_wr(C, 8'h06);
    peek(C, v); check("R10 second start refused", v, 8'h0C);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    bus_wr(A, 8'h30); bus_wr(D, 8'h99); bus_wr(C, 8'h04);
    bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(C, 8'h06);
    bus_wr(C, 8'h05);
    peek(C, v); check("R8 read ignored while busy", v, 8'h06);
    bus_wr(K, 8'h55); bus_wr(K, 8'hAA); bus_wr(C, 8'h06);
    peek(C, v); check("R8 start ignored while busy", v, 8'h06);
    for (int i = 0; i < 40 && v[1]; i++) begin @(negedge clk); peek(C, v); end
    check("R8 job finished without error", v, 8'h14);
    read_byte(8'h30, v); check("R8 latched byte written", v, 8'h99);
  endtask

  task automatic t_retain;
    logic [7:0] v;
    write_byte(8'h7F, 8'h5E);
    bus_wr(K, 8'h55); bus_wr(K, 8'hAA);
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    peek(C, v); check("R1 ctrl cleared by reset", v, 8'h00);
    check("R1 done_o cleared by reset", {7'd0, done_o}, 8'h00);
    bus_wr(C, 8'h06);
    peek(C, v); check("R1 key dropped by reset", v, 8'h0C);
    read_byte(8'h7F, v); check("R9 contents kept over reset", v, 8'h5E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_regs; t_write_read; t_overwrite; t_bad_key;
    t_wen_low; t_key_used; t_busy; t_retain;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule